// File: doc/BRIEF.md
# UART Interrupt Request and Power-State Controller

This block sits beside a small UART and combines four event sources into one active-low interrupt request for the host. The sources are: the transmit buffer having drained, the receive FIFO holding data, a received word that carried a high parity bit, and a shared source. In normal operation the shared source reports a framing error. While the UART is in its low-power state, it reports activity on the receive line instead. Each source has its own enable bit. The request line is a combinational function of the registered source flags and the enable bits.

Software can request the low-power state with a configuration bit, and a board-level pin can force it. Either request alone is enough. While the block is in this state, every level change on the asynchronous RX line sets a sticky activity flag, so that the host can be woken when traffic arrives. The flag is cleared once the low-power state ends. The parity flag lets a 9-bit network mark address bytes: the sender sets the ninth bit on addresses only, and an enabled parity interrupt then fires only on those bytes.

Top module: `uart_irq_pwr_ctrl`

## Requirements
- R1: After reset, irqN is 1, shdnActive is 0 and all four statusFlags bits are 0.
- R2: statusFlags[0] (transmit done) equals the txBufEmpty input sampled at the previous clock edge.
- R3: statusFlags[1] (data received) equals the rxFifoNotEmpty input sampled at the previous clock edge.
- R4: On an edge where rxWordValid is 1, the parity flag statusFlags[2] loads rxParity. On an edge where rxWordValid is 0 and rxFifoNotEmpty is 0, it clears. On any other edge it holds. If a word arrives in the same cycle that the FIFO reports empty, the word wins.
- R5: The framing-error flag follows the same load, clear and hold rules as R4, using rxFrameErr as its data.
- R6: shdnActive is 1 on the edge after a cycle in which swShdn is 1 or hwShdnN is 0. Otherwise it is 0, so the hardware pin takes effect whatever swShdn holds.
- R7: statusFlags[3] shows the receive-activity flag while shdnActive is 1, and the framing-error flag while shdnActive is 0.
- R8: While shdnActive is 1, a level change on rxLine sets the activity flag SYNC_STAGES+1 edges later, and the flag stays set. While shdnActive is 0, the flag is cleared.
- R9: RX transitions that occur while shdnActive is 0 do not set the activity flag.
- R10: irqN is 0 exactly when statusFlags[i] and irqMask[i] are both 1 for some i. Bit 0 enables transmit done, bit 1 data received, bit 2 parity and bit 3 the shared source. irqN responds to irqMask in the same cycle.
- R11: A source whose irqMask bit is 0 never pulls irqN low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txBufEmpty | input | 1 | Transmit buffer empty level |
| rxFifoNotEmpty | input | 1 | Receive FIFO holds at least one word |
| rxWordValid | input | 1 | Strobe: a received word is complete |
| rxParity | input | 1 | Ninth (parity/address) bit of the completed word |
| rxFrameErr | input | 1 | Framing error of the completed word |
| irqMask | input | 4 | Per-source interrupt enables |
| swShdn | input | 1 | Software low-power request |
| hwShdnN | input | 1 | Hardware low-power request, active low |
| rxLine | input | 1 | Raw asynchronous RX line |
| irqN | output | 1 | Interrupt request, active low |
| shdnActive | output | 1 | Low-power state in effect |
| statusFlags | output | 4 | Registered source flags, same bit order as irqMask |

## Verification
Two kinds of collision are provoked deliberately. In the first, a word completes with its parity and framing bits set in the same cycle that the FIFO reports empty. The test checks that the flags take the word's values on the next edge, and that they clear only on the edge after the strobe ends. In the second, the shared status bit changes meaning in the cycle the power state changes. A framing error is latched first, and the test then checks that entering the low-power state shows a clear activity flag and that leaving it shows the framing error again. It also checks that activity seen during one low-power period is gone when the next period begins.

// File: rtl/irq_pwr_pkg.sv
package irq_pwr_pkg;
  localparam int SRC_COUNT = 4;
  localparam int SRC_TX    = 0;
  localparam int SRC_RX    = 1;
  localparam int SRC_PAR   = 2;
  localparam int SRC_SHARE = 3;

  // Strobes from the power/line control to the flag datapath
  typedef struct packed {
    logic raSet;     // RX transition seen while powered down
    logic raClr;     // not powered down: drop activity
    logic showRa;    // shared bit selects activity
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_pwr_ctrl.sv
module irq_pwr_ctrl
  import irq_pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         swShdn,
  input  logic         hwShdnN,
  input  logic         rxLine,
  output logic         shdnReg,
  output ctrl_strobe_t strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxPrev;
  logic                   rxEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shdnReg <= 1'b0;
    else       shdnReg <= swShdn | ~hwShdnN;
  end

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= rxLine;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b1;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= 1'b1;
    else       rxPrev <= syncQ[LAST];
  end

  assign rxEdge = syncQ[LAST] ^ rxPrev;

  always_comb begin
    strobes.raSet  = shdnReg & rxEdge;
    strobes.raClr  = ~shdnReg;
    strobes.showRa = shdnReg;
  end
endmodule

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_pwr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         strobes,
  input  logic                 txBufEmpty,
  input  logic                 rxFifoNotEmpty,
  input  logic                 rxWordValid,
  input  logic                 rxParity,
  input  logic                 rxFrameErr,
  input  logic [SRC_COUNT-1:0] irqMask,
  output logic [SRC_COUNT-1:0] flags,
  output logic                 irqN
);
  logic txFlag, rxFlag, parFlag, feFlag, raFlag;
  logic [SRC_COUNT-1:0] pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFlag <= 1'b0;
      rxFlag <= 1'b0;
    end else begin
      txFlag <= txBufEmpty;
      rxFlag <= rxFifoNotEmpty;
    end
  end

  // Word capture has priority over the empty-FIFO clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parFlag <= 1'b0;
      feFlag  <= 1'b0;
    end else if (rxWordValid) begin
      parFlag <= rxParity;
      feFlag  <= rxFrameErr;
    end else if (!rxFifoNotEmpty) begin
      parFlag <= 1'b0;
      feFlag  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              raFlag <= 1'b0;
    else if (strobes.raClr) raFlag <= 1'b0;
    else if (strobes.raSet) raFlag <= 1'b1;
  end

  always_comb begin
    flags            = '0;
    flags[SRC_TX]    = txFlag;
    flags[SRC_RX]    = rxFlag;
    flags[SRC_PAR]   = parFlag;
    flags[SRC_SHARE] = strobes.showRa ? raFlag : feFlag;
  end

  assign pending = flags & irqMask;
  assign irqN    = ~(|pending);
endmodule

// File: rtl/uart_irq_pwr_ctrl.sv
module uart_irq_pwr_ctrl
  import irq_pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txBufEmpty,
  input  logic       rxFifoNotEmpty,
  input  logic       rxWordValid,
  input  logic       rxParity,
  input  logic       rxFrameErr,
  input  logic [3:0] irqMask,
  input  logic       swShdn,
  input  logic       hwShdnN,
  input  logic       rxLine,
  output logic       irqN,
  output logic       shdnActive,
  output logic [3:0] statusFlags
);
  ctrl_strobe_t strobes;

  irq_pwr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .swShdn  (swShdn),
    .hwShdnN (hwShdnN),
    .rxLine  (rxLine),
    .shdnReg (shdnActive),
    .strobes (strobes)
  );

  irq_flag_dp dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .txBufEmpty     (txBufEmpty),
    .rxFifoNotEmpty (rxFifoNotEmpty),
    .rxWordValid    (rxWordValid),
    .rxParity       (rxParity),
    .rxFrameErr     (rxFrameErr),
    .irqMask        (irqMask),
    .flags          (statusFlags),
    .irqN           (irqN)
  );
endmodule

// File: rtl/uart_irq_pwr_ctrl_chk.sv
module uart_irq_pwr_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txBufEmpty,
  input logic       rxFifoNotEmpty,
  input logic       rxWordValid,
  input logic       rxParity,
  input logic       swShdn,
  input logic       hwShdnN,
  input logic [3:0] irqMask,
  input logic       irqN,
  input logic       shdnActive,
  input logic [3:0] statusFlags
);
  p_tx_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    txBufEmpty |=> statusFlags[0]);

  p_rx_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rxFifoNotEmpty |=> !statusFlags[1]);

  p_par_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxWordValid |=> (statusFlags[2] == $past(rxParity)));

  p_shdn_enter_r6: assert property (@(posedge clk) disable iff (!rstN)
    (swShdn || !hwShdnN) |=> shdnActive);

  p_shdn_leave_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!swShdn && hwShdnN) |=> !shdnActive);

  p_ra_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (shdnActive && statusFlags[3]) |=> (statusFlags[3] || !shdnActive));

  p_irq_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusFlags & irqMask)) |-> !irqN);

  p_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((statusFlags & irqMask) == 4'b0) |-> irqN);
endmodule

bind uart_irq_pwr_ctrl uart_irq_pwr_ctrl_chk chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .txBufEmpty     (txBufEmpty),
  .rxFifoNotEmpty (rxFifoNotEmpty),
  .rxWordValid    (rxWordValid),
  .rxParity       (rxParity),
  .swShdn         (swShdn),
  .hwShdnN        (hwShdnN),
  .irqMask        (irqMask),
  .irqN           (irqN),
  .shdnActive     (shdnActive),
  .statusFlags    (statusFlags)
);

// File: tb/uart_irq_pwr_ctrl_tb_top.sv
module uart_irq_pwr_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txBufEmpty = 1'b0;
  logic       rxFifoNotEmpty = 1'b0;
  logic       rxWordValid = 1'b0;
  logic       rxParity = 1'b0;
  logic       rxFrameErr = 1'b0;
  logic [3:0] irqMask = 4'b0;
  logic       swShdn = 1'b0;
  logic       hwShdnN = 1'b1;
  logic       rxLine = 1'b1;
  logic       irqN;
  logic       shdnActive;
  logic [3:0] statusFlags;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_irq_pwr_ctrl #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .txBufEmpty(txBufEmpty),
    .rxFifoNotEmpty(rxFifoNotEmpty), .rxWordValid(rxWordValid),
    .rxParity(rxParity), .rxFrameErr(rxFrameErr), .irqMask(irqMask),
    .swShdn(swShdn), .hwShdnN(hwShdnN), .rxLine(rxLine),
    .irqN(irqN), .shdnActive(shdnActive), .statusFlags(statusFlags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irqN", irqN, 1);
    chk("R1 shdnActive", shdnActive, 0);
    chk("R1 statusFlags", statusFlags, 0);
  endtask

  task automatic t_tx_rx;
    txBufEmpty = 1; irqMask = 4'b0001;
    #1 chk("R2 flag not yet", statusFlags[0], 0);
    step(1);
    chk("R2 tx flag", statusFlags[0], 1);
    chk("R10 tx irq", irqN, 0);
    txBufEmpty = 0; rxFifoNotEmpty = 1; irqMask = 4'b0010;
    step(1);
    chk("R2 tx flag drop", statusFlags[0], 0);
    chk("R3 rx flag", statusFlags[1], 1);
    chk("R10 rx irq", irqN, 0);
    rxFifoNotEmpty = 0;
    step(1);
    chk("R3 rx flag drop", statusFlags[1], 0);
    chk("R10 irq release", irqN, 1);
  endtask

  task automatic t_parity_frame;
    rxFifoNotEmpty = 1; rxWordValid = 1; rxParity = 1; rxFrameErr = 0;
    irqMask = 4'b0100;
    step(1);
    rxWordValid = 0; rxParity = 0;
    chk("R4 address word", statusFlags[2], 1);
    chk("R10 parity irq", irqN, 0);
    step(2);
    chk("R4 hold", statusFlags[2], 1);
    rxWordValid = 1; rxParity = 0; rxFrameErr = 1; irqMask = 4'b1000;
    step(1);
    rxWordValid = 0; rxFrameErr = 0;
    chk("R4 data word", statusFlags[2], 0);
    chk("R5 frame err", statusFlags[3], 1);
    chk("R10 frame irq", irqN, 0);
    rxFifoNotEmpty = 0;
    step(1);
    chk("R5 clear on empty", statusFlags[3], 0);
    step(1);
  endtask

  task automatic t_capture_vs_empty;
    rxFifoNotEmpty = 0; rxWordValid = 1; rxParity = 1; rxFrameErr = 1;
    step(1);
    rxWordValid = 0; rxParity = 0; rxFrameErr = 0;
    chk("R4 capture wins", statusFlags[2], 1);
    chk("R5 capture wins", statusFlags[3], 1);
    step(1);
    chk("R4 empty clears", statusFlags[2], 0);
    chk("R5 empty clears", statusFlags[3], 0);
  endtask

  task automatic t_shutdown_req;
    swShdn = 1;
    step(1);
    chk("R6 sw enter", shdnActive, 1);
    swShdn = 0; hwShdnN = 0;
    step(1);
    chk("R6 hw alone", shdnActive, 1);
    swShdn = 1;
    step(1);
    chk("R6 both", shdnActive, 1);
    swShdn = 0; hwShdnN = 1;
    step(1);
    chk("R6 leave", shdnActive, 0);
    step(1);
  endtask

  task automatic t_activity;
    swShdn = 1; irqMask = 4'b1000;
    step(1);
    chk("R8 ra clear on entry", statusFlags[3], 0);
    chk("R11 no irq yet", irqN, 1);
    rxLine = 0;
    step(2);
    chk("R8 ra latency", statusFlags[3], 0);
    step(1);
    chk("R8 ra set", statusFlags[3], 1);
    chk("R10 ra irq", irqN, 0);
    rxLine = 1;
    step(4);
    chk("R8 ra sticky", statusFlags[3], 1);
    irqMask = 4'b0111;
    #1 chk("R11 ra masked", irqN, 1);
    swShdn = 0;
    step(2);
    swShdn = 1;
    step(1);
    chk("R8 ra cleared after exit", statusFlags[3], 0);
    swShdn = 0;
    step(2);
  endtask

  task automatic t_ignored_activity;
    rxLine = 0; step(2); rxLine = 1; step(4);
    swShdn = 1;
    step(1);
    chk("R9 normal-mode edges ignored", statusFlags[3], 0);
    swShdn = 0;
    step(2);
  endtask

  task automatic t_shared_bit;
    rxFifoNotEmpty = 1; rxWordValid = 1; rxFrameErr = 1;
    step(1);
    rxWordValid = 0; rxFrameErr = 0;
    chk("R7 normal shows fe", statusFlags[3], 1);
    swShdn = 1;
    step(1);
    chk("R7 shutdown shows ra", statusFlags[3], 0);
    swShdn = 0;
    step(1);
    chk("R7 fe back", statusFlags[3], 1);
    rxFifoNotEmpty = 0;
    step(2);
  endtask

  task automatic t_masks;
    txBufEmpty = 1; rxFifoNotEmpty = 1; rxWordValid = 1; rxParity = 1; rxFrameErr = 1;
    irqMask = 4'b0000;
    step(1);
    rxWordValid = 0;
    chk("R11 all masked", irqN, 1);
    chk("R10 all flags", statusFlags, 4'hF);
    for (int i = 0; i < 4; i++) begin
      irqMask = 4'b0001 << i;
      #1 chk("R10 single mask", irqN, 0);
    end
    txBufEmpty = 0; rxFifoNotEmpty = 0; irqMask = 4'b0001;
    step(1);
    chk("R11 remaining sources masked", irqN, 1);
    irqMask = 4'b0;
  endtask

  initial begin
    step(1);
    #1 t_reset();
    step(2);
    rstN = 1;
    step(1);
    t_reset();
    t_tx_rx();
    t_parity_frame();
    t_capture_vs_empty();
    t_shutdown_req();
    t_activity();
    t_ignored_activity();
    t_shared_bit();
    t_masks();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule